// File: doc/BRIEF.md
# DMA Control Register Bank

This block is the software-visible control and status register bank of a multi-channel DMA controller that serves up to 32 channels. It sits on a simple 32-bit register bus with a single-cycle write strobe and a combinational read path. It keeps the global enable, the channel protection bits and the descriptor table base. Five per-channel attributes (enable, request mask, burst use, alternate descriptor select, high priority) are held as bit vectors. Each vector has a set address and a clear address, so software can change single bits without a read-modify-write sequence.

The engine reports its state and pulses one done line per channel when a transfer finishes. Each pulse latches a completion flag, and software clears flags through a write-one-to-clear address. A main interrupt summarises all flags. A small number of auxiliary interrupt lines can each follow one chosen channel. The bank also holds a per-channel peripheral source select and a software trigger that issues one-cycle request pulses. The engine and the request arbiter sit outside this block.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset, every attribute vector, completion flag, source select, auxiliary config, descriptor base, global enable and protection field is zero, and `sw_req`, `irq_main` and `irq_aux` are low.
- R2: Each attribute has a set address (byte 0x20 + 8·k) and a clear address (0x24 + 8·k), with k = 0 enable, 1 request mask, 2 burst, 3 alternate select, 4 priority. A 1 written to either address sets or clears that bit, and a 0 leaves it unchanged. Reading the set address returns the vector. Reading the clear address returns zero.
- R3: A write to the config address (0x04) loads the global enable from bit 0 and the protection field from bits 7:5. The config address reads as zero.
- R4: The status address (0x00) returns the global enable in bit 0, `eng_state` in bits 7:4, the channel count minus one in bits 20:16 and the test indicator parameter in bits 31:28. All other bits read as zero.
- R5: The descriptor base (0x08) stores the written value with its low log2(NUM_CH·32) bits forced to zero. The read-only alternate base (0x0C) returns the base plus NUM_CH·16.
- R6: A write to the trigger address (0x10) drives the written channel bits on `sw_req` for exactly the next cycle. Otherwise `sw_req` is zero, and the address reads as zero.
- R7: A done pulse sets that channel's flag, which is readable at 0x14. A 1 written at 0x18 clears a flag. When a done pulse and a clear hit the same bit in the same cycle, the flag ends set.
- R8: `irq_main` is high exactly when at least one completion flag is set.
- R9: Auxiliary line j is configured at 0x50 + 4·j, with a channel select in bits 4:0 and an enable in bit 5. The line is high when it is enabled and the flag of the selected channel is set. A select at or beyond the channel count never asserts the line.
- R10: Channel c has a source select at 0x100 + 4·c that keeps the low SEL_W bits of the write. The value drives `src_sel[c·SEL_W +: SEL_W]`.
- R11: A misaligned or unmapped address reads as zero, and a write to one changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_done | input | NUM_CH | Per-channel completion pulses from the engine |
| eng_state | input | 4 | Engine state code |
| master_en | output | 1 | Global controller enable |
| prot_ctrl | output | 3 | Channel protection control |
| desc_base | output | 32 | Primary descriptor table base |
| ch_enable | output | NUM_CH | Channel enables |
| ch_reqmask | output | NUM_CH | Peripheral request masks |
| ch_burst | output | NUM_CH | Burst-only request use |
| ch_altsel | output | NUM_CH | Alternate descriptor select |
| ch_prio | output | NUM_CH | High priority select |
| sw_req | output | NUM_CH | One-cycle software request pulses |
| src_sel | output | NUM_CH*SEL_W | Per-channel peripheral source select |
| irq_main | output | 1 | OR of all completion flags |
| irq_aux | output | NUM_AUX | Routed single-channel interrupts |

## Verification
The assertions take for granted that every register access is a single-cycle write strobe with a stable address. They also assume that `eng_done` carries pulses and not levels, so a flag set in one cycle stays visible on `irq_main` in the next unless a clear arrives without a matching pulse. The stimulus changes inputs only on the falling clock edge and holds every write for exactly one rising edge. It drives the done lines only for single cycles, including one cycle that collides a done pulse with a clear of the same bit. It moves `eng_state` only while no status check is pending.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
   localparam int unsigned OFF_STATUS = 32'h000;
   localparam int unsigned OFF_CFG    = 32'h004;
   localparam int unsigned OFF_BASE   = 32'h008;
   localparam int unsigned OFF_ALTB   = 32'h00C;
   localparam int unsigned OFF_TRIG   = 32'h010;
   localparam int unsigned OFF_FLAGS  = 32'h014;
   localparam int unsigned OFF_FCLR   = 32'h018;
   localparam int unsigned OFF_ATTR   = 32'h020;
   localparam int unsigned OFF_AUX    = 32'h050;
   localparam int unsigned OFF_SRC    = 32'h100;

   typedef enum int unsigned {
      ATTR_EN  = 0,
      ATTR_RQM = 1,
      ATTR_BST = 2,
      ATTR_ALT = 3,
      ATTR_PRI = 4
   } attr_e;
   localparam int unsigned NUM_ATTR = 5;

   localparam int unsigned AUX_CFG_W = 6;

   function automatic int unsigned attr_set_off(input int unsigned k);
      return OFF_ATTR + 8 * k;
   endfunction

   function automatic int unsigned attr_clr_off(input int unsigned k);
      return OFF_ATTR + 8 * k + 4;
   endfunction
endpackage

// File: rtl/dma_setclr_vec.sv
module dma_setclr_vec #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] vec
);
   logic [W-1:0] set_m, clr_m;

   assign set_m = set_we ? wdata : '0;
   assign clr_m = clr_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vec <= '0;
      else        vec <= (vec | set_m) & ~clr_m;
   end
endmodule

// File: rtl/dma_done_flags.sv
module dma_done_flags #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] done,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] flags
);
   logic [W-1:0] clr_m;

   assign clr_m = clr_we ? wdata : '0;

   // The done term is ORed in after the clear mask so a collision leaves the flag set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_m) | done;
   end
endmodule

// File: rtl/dma_aux_route.sv
module dma_aux_route #(
   parameter int unsigned NUM_CH  = 32,
   parameter int unsigned NUM_AUX = 3
) (
   input  logic [NUM_CH-1:0]                                 flags,
   input  logic [NUM_AUX-1:0][dma_regs_pkg::AUX_CFG_W-1:0] cfg,
   output logic [NUM_AUX-1:0]                                irq
);
   logic [31:0] flags_pad;

   assign flags_pad = 32'(flags);

   for (genvar j = 0; j < NUM_AUX; j++) begin : g_line
      logic [4:0] sel;
      logic       en;
      assign sel    = cfg[j][4:0];
      assign en     = cfg[j][5];
      assign irq[j] = en && flags_pad[sel];
   end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
   import dma_regs_pkg::*;
#(
   parameter int unsigned NUM_CH   = 32,
   parameter int unsigned NUM_AUX  = 3,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned ADDR_W   = 10,
   parameter logic [3:0]  TEST_IND = 4'h0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [31:0]             bus_wdata,
   output logic [31:0]             bus_rdata,
   input  logic [NUM_CH-1:0]       eng_done,
   input  logic [3:0]              eng_state,
   output logic                    master_en,
   output logic [2:0]              prot_ctrl,
   output logic [31:0]             desc_base,
   output logic [NUM_CH-1:0]       ch_enable,
   output logic [NUM_CH-1:0]       ch_reqmask,
   output logic [NUM_CH-1:0]       ch_burst,
   output logic [NUM_CH-1:0]       ch_altsel,
   output logic [NUM_CH-1:0]       ch_prio,
   output logic [NUM_CH-1:0]       sw_req,
   output logic [NUM_CH*SEL_W-1:0] src_sel,
   output logic                    irq_main,
   output logic [NUM_AUX-1:0]      irq_aux
);
   localparam int unsigned ALIGN_BITS = $clog2(NUM_CH * 32);
   localparam logic [31:0] BASE_MASK  = ~((32'd1 << ALIGN_BITS) - 32'd1);
   localparam logic [31:0] ALT_OFFSET = 32'(NUM_CH * 16);

   initial begin
      if (NUM_CH < 2 || NUM_CH > 32) $error("NUM_CH must be 2..32");
      if (NUM_AUX < 1 || NUM_AUX > 4) $error("NUM_AUX must be 1..4");
      if (SEL_W < 1 || SEL_W > 8) $error("SEL_W must be 1..8");
      if (OFF_SRC + 4 * NUM_CH > (1 << ADDR_W)) $error("ADDR_W too small");
   end

   logic addr_ok;
   assign addr_ok = (bus_addr[1:0] == 2'b00);

   function automatic logic hit(input int unsigned off);
      return addr_ok && (bus_addr == ADDR_W'(off));
   endfunction

   logic [NUM_ATTR-1:0]                  we_set, we_clr;
   logic [NUM_AUX-1:0]                   we_aux;
   logic [NUM_CH-1:0]                    we_src;
   logic                                 we_cfg, we_base, we_trig, we_fclr;

   always_comb begin
      we_cfg  = bus_wr && hit(OFF_CFG);
      we_base = bus_wr && hit(OFF_BASE);
      we_trig = bus_wr && hit(OFF_TRIG);
      we_fclr = bus_wr && hit(OFF_FCLR);
      for (int k = 0; k < NUM_ATTR; k++) begin
         we_set[k] = bus_wr && hit(attr_set_off(k));
         we_clr[k] = bus_wr && hit(attr_clr_off(k));
      end
      for (int j = 0; j < NUM_AUX; j++) we_aux[j] = bus_wr && hit(OFF_AUX + 4 * j);
      for (int c = 0; c < NUM_CH; c++)  we_src[c] = bus_wr && hit(OFF_SRC + 4 * c);
   end

   // Global registers
   logic [NUM_AUX-1:0][AUX_CFG_W-1:0] aux_cfg_q;
   logic [NUM_CH-1:0][SEL_W-1:0]      src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_en <= 1'b0;
         prot_ctrl <= '0;
         desc_base <= '0;
         sw_req    <= '0;
         aux_cfg_q <= '0;
         src_q     <= '0;
      end else begin
         if (we_cfg) begin
            master_en <= bus_wdata[0];
            prot_ctrl <= bus_wdata[7:5];
         end
         if (we_base) desc_base <= bus_wdata & BASE_MASK;
         sw_req <= we_trig ? bus_wdata[NUM_CH-1:0] : '0;
         for (int j = 0; j < NUM_AUX; j++)
            if (we_aux[j]) aux_cfg_q[j] <= bus_wdata[AUX_CFG_W-1:0];
         for (int c = 0; c < NUM_CH; c++)
            if (we_src[c]) src_q[c] <= bus_wdata[SEL_W-1:0];
      end
   end

   assign src_sel = src_q;

   // Attribute vectors
   logic [NUM_ATTR-1:0][NUM_CH-1:0] attr_vec;

   for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
      dma_setclr_vec #(.W(NUM_CH)) u_vec (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_we (we_set[k]),
         .clr_we (we_clr[k]),
         .wdata  (bus_wdata[NUM_CH-1:0]),
         .vec    (attr_vec[k])
      );
   end

   assign ch_enable  = attr_vec[ATTR_EN];
   assign ch_reqmask = attr_vec[ATTR_RQM];
   assign ch_burst   = attr_vec[ATTR_BST];
   assign ch_altsel  = attr_vec[ATTR_ALT];
   assign ch_prio    = attr_vec[ATTR_PRI];

   // Completion flags and interrupts
   logic [NUM_CH-1:0] flags;

   dma_done_flags #(.W(NUM_CH)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .done   (eng_done),
      .clr_we (we_fclr),
      .wdata  (bus_wdata[NUM_CH-1:0]),
      .flags  (flags)
   );

   assign irq_main = |flags;

   dma_aux_route #(.NUM_CH(NUM_CH), .NUM_AUX(NUM_AUX)) u_aux (
      .flags (flags),
      .cfg   (aux_cfg_q),
      .irq   (irq_aux)
   );

   // Read path
   always_comb begin
      bus_rdata = '0;
      if (hit(OFF_STATUS))
         bus_rdata = {TEST_IND, 7'd0, 5'(NUM_CH - 1), 8'd0, eng_state, 3'd0, master_en};
      if (hit(OFF_BASE))  bus_rdata = desc_base;
      if (hit(OFF_ALTB))  bus_rdata = desc_base + ALT_OFFSET;
      if (hit(OFF_FLAGS)) bus_rdata = 32'(flags);
      for (int k = 0; k < NUM_ATTR; k++)
         if (hit(attr_set_off(k))) bus_rdata = 32'(attr_vec[k]);
      for (int j = 0; j < NUM_AUX; j++)
         if (hit(OFF_AUX + 4 * j)) bus_rdata = 32'(aux_cfg_q[j]);
      for (int c = 0; c < NUM_CH; c++)
         if (hit(OFF_SRC + 4 * c)) bus_rdata = 32'(src_q[c]);
   end
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk #(
   parameter int unsigned NUM_CH  = 32,
   parameter int unsigned NUM_AUX = 3,
   parameter int unsigned ADDR_W  = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_wdata,
   input logic [31:0]        bus_rdata,
   input logic [NUM_CH-1:0]  eng_done,
   input logic [NUM_CH-1:0]  ch_enable,
   input logic [NUM_CH-1:0]  sw_req,
   input logic               irq_main,
   input logic [NUM_AUX-1:0] irq_aux
);
   localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(dma_regs_pkg::attr_set_off(0));
   localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(dma_regs_pkg::attr_clr_off(0));
   localparam logic [ADDR_W-1:0] A_TRIG   = ADDR_W'(dma_regs_pkg::OFF_TRIG);
   localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(dma_regs_pkg::OFF_STATUS);

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_EN_SET |=>
      (ch_enable & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])); // R2

   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_EN_CLR |=>
      (ch_enable & $past(bus_wdata[NUM_CH-1:0])) == '0); // R2

   AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == A_TRIG) |=> sw_req == '0); // R6

   AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done != '0 |=> irq_main); // R7

   AST_AUX_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_aux != '0 |-> irq_main); // R9

   AST_STATUS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == A_STAT |-> bus_rdata[20:16] == 5'(NUM_CH - 1)); // R4
endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(
   .NUM_CH  (NUM_CH),
   .NUM_AUX (NUM_AUX),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .eng_done  (eng_done),
   .ch_enable (ch_enable),
   .sw_req    (sw_req),
   .irq_main  (irq_main),
   .irq_aux   (irq_aux)
);

// File: tb/tb_dma_ctl_regs.sv
module tb_dma_ctl_regs;
   localparam int NCH = 32;
   localparam int NAUX = 3;
   localparam int SW = 3;
   localparam int AW = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [AW-1:0]     bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NCH-1:0]    eng_done = '0;
   logic [3:0]        eng_state = '0;
   logic              master_en;
   logic [2:0]        prot_ctrl;
   logic [31:0]       desc_base;
   logic [NCH-1:0]    ch_enable, ch_reqmask, ch_burst, ch_altsel, ch_prio, sw_req;
   logic [NCH*SW-1:0] src_sel;
   logic              irq_main;
   logic [NAUX-1:0]   irq_aux;

   always #2 clk = ~clk;

   dma_ctl_regs #(.NUM_CH(NCH), .NUM_AUX(NAUX), .SEL_W(SW), .ADDR_W(AW)) dut (
      .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .eng_done, .eng_state,
      .master_en, .prot_ctrl, .desc_base, .ch_enable, .ch_reqmask, .ch_burst,
      .ch_altsel, .ch_prio, .sw_req, .src_sel, .irq_main, .irq_aux
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1 chk(tag, bus_rdata, exp);
   endtask

   typedef struct packed {
      logic        wr;
      logic [9:0]  addr;
      logic [31:0] data;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 10'h020, 32'h0000_00F0},   // R2 enable set
      '{1'b0, 10'h020, 32'h0000_00F0},
      '{1'b1, 10'h020, 32'h0001_0001},
      '{1'b0, 10'h020, 32'h0001_00F1},
      '{1'b1, 10'h024, 32'h0000_0030},   // R2 enable clear
      '{1'b0, 10'h020, 32'h0001_00C1},
      '{1'b0, 10'h024, 32'h0000_0000},
      '{1'b1, 10'h040, 32'h8000_0000},   // R2 priority
      '{1'b0, 10'h040, 32'h8000_0000},
      '{1'b0, 10'h020, 32'h0001_00C1},
      '{1'b1, 10'h028, 32'hFFFF_FFFF},   // R2 request mask
      '{1'b1, 10'h02C, 32'h0F0F_0F0F},
      '{1'b0, 10'h028, 32'hF0F0_F0F0},
      '{1'b1, 10'h030, 32'h0000_0003},   // R2 burst / alternate
      '{1'b1, 10'h038, 32'h0000_0005},
      '{1'b0, 10'h038, 32'h0000_0005},
      '{1'b0, 10'h030, 32'h0000_0003},
      '{1'b1, 10'h008, 32'h2000_07FF},   // R5 base alignment
      '{1'b0, 10'h008, 32'h2000_0400},
      '{1'b0, 10'h00C, 32'h2000_0600},
      '{1'b1, 10'h114, 32'h0000_00FF},   // R10 source select ch5
      '{1'b0, 10'h114, 32'h0000_0007},
      '{1'b1, 10'h0FC, 32'hFFFF_FFFF},   // R11 unmapped
      '{1'b0, 10'h0FC, 32'h0000_0000}
   };

   initial begin
      #(4 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ch_enable", 32'(ch_enable), 32'h0);
      chk("R1 irq", {28'd0, irq_aux, irq_main}, 32'h0);
      chk("R1 master_en", 32'(master_en), 32'h0);
      rst_n = 1'b1;
      rd("R1 flags", 10'h014, 32'h0);
      rd("R1 base", 10'h008, 32'h0);
      rd("R1 src", 10'h100, 32'h0);
      chk("R1 sw_req", 32'(sw_req), 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (TBL[i].wr) wr(TBL[i].addr, TBL[i].data);
         else rd($sformatf("R2/R5/R10/R11 vector %0d", i), TBL[i].addr, TBL[i].data);
      end
      chk("R2 ch_enable port", 32'(ch_enable), 32'h0001_00C1);
      chk("R2 ch_reqmask port", 32'(ch_reqmask), 32'hF0F0_F0F0);
      chk("R2 ch_altsel port", 32'(ch_altsel), 32'h0000_0005);
      chk("R2 ch_prio port", 32'(ch_prio), 32'h8000_0000);
      chk("R2 ch_burst port", 32'(ch_burst), 32'h0000_0003);
      chk("R5 desc_base port", desc_base, 32'h2000_0400);
      chk("R10 src_sel ch5", 32'(src_sel[5*SW +: SW]), 32'h7);
      chk("R10 src_sel ch4", 32'(src_sel[4*SW +: SW]), 32'h0);
      rd("R11 misaligned", 10'h021, 32'h0);

      // R3 / R4 config and status
      eng_state = 4'h5;
      wr(10'h004, 32'h0000_00E1);
      chk("R3 prot_ctrl", 32'(prot_ctrl), 32'h7);
      chk("R3 master_en", 32'(master_en), 32'h1);
      rd("R3 cfg reads zero", 10'h004, 32'h0);
      rd("R4 status", 10'h000, 32'h001F_0051);
      wr(10'h004, 32'h0);
      rd("R4 status disabled", 10'h000, 32'h001F_0050);

      // R6 software trigger
      wr(10'h010, 32'h0000_0104);
      chk("R6 sw_req pulse", 32'(sw_req), 32'h0000_0104);
      @(negedge clk);
      chk("R6 sw_req ends", 32'(sw_req), 32'h0);
      rd("R6 trig reads zero", 10'h010, 32'h0);

      // R9 aux config, R7/R8 flags
      wr(10'h050, 32'h0000_0023);
      wr(10'h054, 32'h0000_0024);
      wr(10'h058, 32'h0000_0003);
      chk("R8 irq idle", 32'(irq_main), 32'h0);
      @(negedge clk); eng_done = 32'h8;
      @(negedge clk); eng_done = '0;
      chk("R8 irq_main", 32'(irq_main), 32'h1);
      chk("R9 aux lines", 32'(irq_aux), 32'h1);
      rd("R7 flags", 10'h014, 32'h8);
      wr(10'h018, 32'h8);
      chk("R7 cleared", 32'(irq_main), 32'h0);
      chk("R9 aux cleared", 32'(irq_aux), 32'h0);
      @(negedge clk);
      eng_done = 32'h8; bus_wr = 1'b1; bus_addr = 10'h018; bus_wdata = 32'h8;
      @(negedge clk);
      eng_done = '0; bus_wr = 1'b0; bus_wdata = '0;
      rd("R7 set wins", 10'h014, 32'h8);
      wr(10'h050, 32'h0000_0025);
      chk("R9 unselected", 32'(irq_aux), 32'h0);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule